// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired sequencer for a processor datapath that executes each instruction over several clock cycles. That datapath shares its resources: one memory serves both instruction and data accesses, and one ALU serves every arithmetic step. Between steps, values are parked in internal holding registers. The sequencer takes the 6-bit opcode field of the latched instruction and a 4-bit step register. From these it produces every mux select and write enable the datapath needs on each cycle.

Every instruction begins with a fetch step and a decode step. The decode step dispatches on the opcode to one of four tails. A load or store first passes through a shared address step and is then split into a read path or a write path. A register-to-register operation computes its result and then writes it back. A conditional branch and an unconditional jump each finish in a single step. As a result, a load takes 5 cycles, a store or register operation takes 4, and a branch or jump takes 3. The outputs are a pure function of the current step (Moore style), and the step number is also brought out.

Top module: `mc_ctrl_seq`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it is released, the step register holds 0 (fetch). `rst` is asynchronous and acts even in the middle of an instruction.
- R2: Step 0 (fetch) drives `pc_wr_en`=1, `mem_rd`=1, `ir_ld`=1, `mem_addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=01, `alu_mode`=00 and `pc_src`=00. It always moves to step 1.
- R3: Step 1 (decode) drives `alu_a_sel`=0, `alu_b_sel`=11 and `alu_mode`=00. It dispatches on the opcode as follows: 100011 (load) or 101011 (store) goes to step 2, 000000 (register operation) goes to step 6, 000100 (branch-if-equal) goes to step 8, and 000010 (jump) goes to step 9.
- R4: Step 2 (address) drives `alu_a_sel`=1, `alu_b_sel`=10 and `alu_mode`=00. It goes to step 3 for opcode 100011 and to step 5 for opcode 101011.
- R5: Step 3 drives `mem_rd`=1 and `mem_addr_sel`=1, then goes to step 4. Step 4 drives `rf_wr`=1, `rf_dst_sel`=0 and `rf_data_sel`=1, then goes to step 0.
- R6: Step 5 drives `mem_wr`=1 and `mem_addr_sel`=1, then goes to step 0.
- R7: Step 6 drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_mode`=10, then goes to step 7. Step 7 drives `rf_wr`=1, `rf_dst_sel`=1 and `rf_data_sel`=0, then goes to step 0.
- R8: Step 8 drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=01, `pc_wr_cond`=1 and `pc_src`=01, then goes to step 0.
- R9: Step 9 drives `pc_wr_en`=1 and `pc_src`=10, then goes to step 0.
- R10: In every step, each output not named for that step is 0. `mem_rd` and `mem_wr` are never 1 together, and `pc_wr_en` and `pc_wr_cond` are never 1 together.
- R11: In step 1, an opcode outside the five listed in R3 sends the machine back to step 0.
- R12: The opcode is ignored in every step other than 1 and 2. The step sequence and the outputs do not change when the opcode changes in those steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| opcode | input | 6 | Opcode field of the latched instruction |
| pc_wr_en | output | 1 | Unconditional program-counter write |
| pc_wr_cond | output | 1 | Program-counter write qualified by ALU zero |
| mem_addr_sel | output | 1 | Memory address from ALU result register (1) or PC (0) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_ld | output | 1 | Load the instruction register |
| rf_data_sel | output | 1 | Register write data from memory data register (1) or ALU result register (0) |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_mode | output | 2 | 00 add, 01 subtract, 10 use function field |
| alu_b_sel | output | 2 | ALU B: 00 reg B, 01 constant 4, 10 sign-extended, 11 shifted sign-extended |
| alu_a_sel | output | 1 | ALU A: 0 PC, 1 reg A |
| rf_wr | output | 1 | Register file write |
| rf_dst_sel | output | 1 | Destination register field: 1 rd, 0 rt |
| state | output | 4 | Current step number |

## Verification
The step number is an output, so a wrong transition shows at the ports on the very next clock edge. It also changes the control word in that same cycle, because the outputs decode the step directly. A dispatch error at decode sends the machine down the wrong tail. That error shows in the cycle after decode as a wrong step and wrong selects, and later as a wrong instruction length. A control word that is wrong only in a single step appears in every cycle the machine spends in that step. The sweep drives every opcode value through decode and scrambles the opcode in the steps that must ignore it, so none of these faults can stay hidden.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int OPC_W  = 6;
  localparam int STEP_W = 4;

  typedef enum logic [STEP_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_MEMRD  = 4'd3,
    ST_LDWB   = 4'd4,
    ST_STORE  = 4'd5,
    ST_REXEC  = 4'd6,
    ST_RWB    = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } step_e;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;

  typedef struct packed {
    logic       pc_wr_en;
    logic       pc_wr_cond;
    logic       mem_addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_ld;
    logic       rf_data_sel;
    logic [1:0] pc_src;
    logic [1:0] alu_mode;
    logic [1:0] alu_b_sel;
    logic       alu_a_sel;
    logic       rf_wr;
    logic       rf_dst_sel;
  } ctl_t;

endpackage

// File: rtl/mc_next_step.sv
module mc_next_step
  import mc_ctrl_pkg::*;
(
  input  logic [STEP_W-1:0] cur,
  input  logic [OPC_W-1:0]  opcode,
  output logic [STEP_W-1:0] nxt,
  output logic              bad_dispatch
);

  function automatic logic known_op(input logic [OPC_W-1:0] op);
    return (op == OPC_LOAD) || (op == OPC_STORE) || (op == OPC_RTYPE) ||
           (op == OPC_BEQ)  || (op == OPC_JUMP);
  endfunction

  function automatic logic [STEP_W-1:0] dispatch(input logic [OPC_W-1:0] op);
    logic [STEP_W-1:0] t;
    unique case (op)
      OPC_LOAD, OPC_STORE: t = ST_ADDR;
      OPC_RTYPE:           t = ST_REXEC;
      OPC_BEQ:             t = ST_BRANCH;
      OPC_JUMP:            t = ST_JUMP;
      default:             t = ST_FETCH;
    endcase
    return t;
  endfunction

  function automatic logic [STEP_W-1:0] follow(input logic [STEP_W-1:0] s,
                                               input logic [OPC_W-1:0]  op);
    logic [STEP_W-1:0] t;
    case (s)
      ST_FETCH:  t = ST_DECODE;
      ST_DECODE: t = dispatch(op);
      ST_ADDR:   t = (op == OPC_LOAD)  ? ST_MEMRD :
                     (op == OPC_STORE) ? ST_STORE : ST_FETCH;
      ST_MEMRD:  t = ST_LDWB;
      ST_REXEC:  t = ST_RWB;
      default:   t = ST_FETCH;
    endcase
    return t;
  endfunction

  always_comb begin
    nxt          = follow(cur, opcode);
    bad_dispatch = (cur == ST_DECODE) && !known_op(opcode);
  end

endmodule

// File: rtl/mc_ctl_decode.sv
module mc_ctl_decode
  import mc_ctrl_pkg::*;
(
  input  logic [STEP_W-1:0] cur,
  output ctl_t              ctl
);

  function automatic ctl_t word_for(input logic [STEP_W-1:0] s);
    ctl_t c;
    c = '0;
    case (s)
      ST_FETCH: begin
        c.pc_wr_en  = 1'b1;
        c.mem_rd    = 1'b1;
        c.ir_ld     = 1'b1;
        c.alu_b_sel = 2'b01;
      end
      ST_DECODE: c.alu_b_sel = 2'b11;
      ST_ADDR: begin
        c.alu_a_sel = 1'b1;
        c.alu_b_sel = 2'b10;
      end
      ST_MEMRD: begin
        c.mem_rd       = 1'b1;
        c.mem_addr_sel = 1'b1;
      end
      ST_LDWB: begin
        c.rf_wr       = 1'b1;
        c.rf_data_sel = 1'b1;
      end
      ST_STORE: begin
        c.mem_wr       = 1'b1;
        c.mem_addr_sel = 1'b1;
      end
      ST_REXEC: begin
        c.alu_a_sel = 1'b1;
        c.alu_mode  = 2'b10;
      end
      ST_RWB: begin
        c.rf_wr      = 1'b1;
        c.rf_dst_sel = 1'b1;
      end
      ST_BRANCH: begin
        c.alu_a_sel  = 1'b1;
        c.alu_mode   = 2'b01;
        c.pc_wr_cond = 1'b1;
        c.pc_src     = 2'b01;
      end
      ST_JUMP: begin
        c.pc_wr_en = 1'b1;
        c.pc_src   = 2'b10;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

  always_comb ctl = word_for(cur);

endmodule

// File: rtl/mc_ctrl_seq.sv
module mc_ctrl_seq
  import mc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [5:0]       opcode,
  output logic             pc_wr_en,
  output logic             pc_wr_cond,
  output logic             mem_addr_sel,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ir_ld,
  output logic             rf_data_sel,
  output logic [1:0]       pc_src,
  output logic [1:0]       alu_mode,
  output logic [1:0]       alu_b_sel,
  output logic             alu_a_sel,
  output logic             rf_wr,
  output logic             rf_dst_sel,
  output logic [3:0]       state
);

  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_d;
  logic              bad_dispatch;
  ctl_t              ctl;

  mc_next_step u_next (
    .cur          (step_q),
    .opcode       (opcode),
    .nxt          (step_d),
    .bad_dispatch (bad_dispatch)
  );

  mc_ctl_decode u_dec (
    .cur (step_q),
    .ctl (ctl)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) step_q <= ST_FETCH;
    else     step_q <= step_d;
  end

  assign state        = step_q;
  assign pc_wr_en     = ctl.pc_wr_en;
  assign pc_wr_cond   = ctl.pc_wr_cond;
  assign mem_addr_sel = ctl.mem_addr_sel;
  assign mem_rd       = ctl.mem_rd;
  assign mem_wr       = ctl.mem_wr;
  assign ir_ld        = ctl.ir_ld;
  assign rf_data_sel  = ctl.rf_data_sel;
  assign pc_src       = ctl.pc_src;
  assign alu_mode     = ctl.alu_mode;
  assign alu_b_sel    = ctl.alu_b_sel;
  assign alu_a_sel    = ctl.alu_a_sel;
  assign rf_wr        = ctl.rf_wr;
  assign rf_dst_sel   = ctl.rf_dst_sel;

  // Reset lands in fetch
  p_reset_fetch_r1: assert property (@(posedge clk) rst |=> step_q == ST_FETCH);

  p_fetch_decode_r2: assert property (@(posedge clk) disable iff (rst)
    step_q == ST_FETCH |=> step_q == ST_DECODE);

  p_irld_fetch_only_r2: assert property (@(posedge clk) disable iff (rst)
    ir_ld |-> step_q == ST_FETCH);

  p_load_dispatch_r3: assert property (@(posedge clk) disable iff (rst)
    (step_q == ST_DECODE && opcode == OPC_LOAD) |=> step_q == ST_ADDR);

  p_store_split_r4: assert property (@(posedge clk) disable iff (rst)
    (step_q == ST_ADDR && opcode == OPC_STORE) |=> step_q == ST_STORE);

  p_memrd_ldwb_r5: assert property (@(posedge clk) disable iff (rst)
    step_q == ST_MEMRD |=> step_q == ST_LDWB);

  p_tail_return_r6: assert property (@(posedge clk) disable iff (rst)
    (step_q == ST_LDWB || step_q == ST_STORE || step_q == ST_RWB ||
     step_q == ST_BRANCH || step_q == ST_JUMP) |=> step_q == ST_FETCH);

  p_mem_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_pc_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(pc_wr_en && pc_wr_cond));

  p_bad_op_fetch_r11: assert property (@(posedge clk) disable iff (rst)
    bad_dispatch |=> step_q == ST_FETCH);

  p_step_legal_r12: assert property (@(posedge clk) disable iff (rst)
    step_q <= ST_JUMP);

endmodule

// File: tb/mc_ctrl_seq_tb.sv
module mc_ctrl_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic       pc_wr_en, pc_wr_cond, mem_addr_sel, mem_rd, mem_wr, ir_ld;
  logic       rf_data_sel, alu_a_sel, rf_wr, rf_dst_sel;
  logic [1:0] pc_src, alu_mode, alu_b_sel;
  logic [3:0] state;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  mc_ctrl_seq u_dut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_wr_en(pc_wr_en), .pc_wr_cond(pc_wr_cond), .mem_addr_sel(mem_addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_ld(ir_ld), .rf_data_sel(rf_data_sel),
    .pc_src(pc_src), .alu_mode(alu_mode), .alu_b_sel(alu_b_sel),
    .alu_a_sel(alu_a_sel), .rf_wr(rf_wr), .rf_dst_sel(rf_dst_sel), .state(state)
  );

  always #10 clk = ~clk;

  // Expected control word, bit order (msb first):
  // pc_wr_en pc_wr_cond mem_addr_sel mem_rd mem_wr ir_ld rf_data_sel
  // pc_src[1:0] alu_mode[1:0] alu_b_sel[1:0] alu_a_sel rf_wr rf_dst_sel
  function automatic logic [15:0] expect_word(input int s);
    logic [15:0] w;
    w = 16'h0;
    if (s == 0) begin w[15] = 1; w[12] = 1; w[10] = 1; w[4:3] = 2'b01; end
    if (s == 1) w[4:3] = 2'b11;
    if (s == 2) begin w[2] = 1; w[4:3] = 2'b10; end
    if (s == 3) begin w[12] = 1; w[13] = 1; end
    if (s == 4) begin w[1] = 1; w[9] = 1; end
    if (s == 5) begin w[11] = 1; w[13] = 1; end
    if (s == 6) begin w[2] = 1; w[6:5] = 2'b10; end
    if (s == 7) begin w[1] = 1; w[0] = 1; end
    if (s == 8) begin w[2] = 1; w[6:5] = 2'b01; w[14] = 1; w[8:7] = 2'b01; end
    if (s == 9) begin w[15] = 1; w[8:7] = 2'b10; end
    return w;
  endfunction

  function automatic int expect_next(input int s, input logic [5:0] op);
    if (s == 0) return 1;
    if (s == 1) begin
      if (op == 6'd35 || op == 6'd43) return 2;
      if (op == 6'd0) return 6;
      if (op == 6'd4) return 8;
      if (op == 6'd2) return 9;
      return 0;
    end
    if (s == 2) return (op == 6'd35) ? 3 : 5;
    if (s == 3) return 4;
    if (s == 6) return 7;
    return 0;
  endfunction

  function automatic string req_tag(input int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4: return "R5";
      5: return "R6";
      6, 7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [15:0] actual_word();
    return {pc_wr_en, pc_wr_cond, mem_addr_sel, mem_rd, mem_wr, ir_ld, rf_data_sel,
            pc_src, alu_mode, alu_b_sel, alu_a_sel, rf_wr, rf_dst_sel};
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // R10: unlisted outputs are zero, verified by full-word compare
  task automatic check_step(input int s, input string req);
    check(state == 4'(s), req, "step", 16'(state), 16'(s));
    check(actual_word() == expect_word(s), req, "control word (R10)",
          actual_word(), expect_word(s));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int exp_s;
    int lens [5];
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_step(0, "R1");
    rst = 1'b0;
    exp_s = 0;

    for (int op = 0; op < 64; op++) begin
      int len;
      len = 0;
      do begin
        check_step(exp_s, req_tag(exp_s));
        // R12: opcode scrambled in steps that must ignore it
        if (exp_s == 1 || exp_s == 2) opcode = 6'(op);
        else opcode = 6'(op) ^ 6'h2A;
        @(posedge clk);
        exp_s = expect_next(exp_s, 6'(op));
        len++;
        @(negedge clk);
      end while (exp_s != 0);
      if (op == 35) lens[0] = len;
      if (op == 43) lens[1] = len;
      if (op == 0)  lens[2] = len;
      if (op == 4)  lens[3] = len;
      if (op == 2)  lens[4] = len;
      // R11: unknown opcodes take exactly fetch+decode
      if (!(op == 35 || op == 43 || op == 0 || op == 4 || op == 2))
        check(len == 2, "R11", "unknown opcode length", 16'(len), 16'd2);
    end
    check(lens[0] == 5, "R5", "load length", 16'(lens[0]), 16'd5);
    check(lens[1] == 4, "R6", "store length", 16'(lens[1]), 16'd4);
    check(lens[2] == 4, "R7", "register op length", 16'(lens[2]), 16'd4);
    check(lens[3] == 3, "R8", "branch length", 16'(lens[3]), 16'd3);
    check(lens[4] == 3, "R9", "jump length", 16'(lens[4]), 16'd3);

    // R1: reset in mid-instruction
    check_step(0, "R1");
    opcode = 6'd35;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check_step(2, "R4");
    rst = 1'b1;
    #1;
    check(state == 4'd0, "R1", "async reset step", 16'(state), 16'd0);
    @(posedge clk); @(negedge clk);
    check_step(0, "R1");
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check_step(1, "R3");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule